// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a vector of already-synchronized input pins and turns selected conditions on each pin into latched interrupt requests. Every pin has four independent trigger enables: rising edge, falling edge, high level and low level. They can be enabled in any combination. The pin raises an event whenever at least one of its enabled conditions holds. Events are kept in a sticky state vector. A separate enable vector decides which state bits reach the single registered interrupt output.

Software reaches the block through a single-cycle request port with valid, write, address and data signals. Reads return one cycle later. The state vector is cleared by writing ones to it. A test register sets state bits as if hardware events had occurred. A read-only address returns the live pin values. Edge detection compares each pin with a copy registered in the previous cycle.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, all four trigger enables, the interrupt enable and the state vector read as zero, and `irq_o` is 0.
- R2: A read of address 7 returns the value present on `pins_i` in the request cycle.
- R3: With the rising enable (address 0) set for a pin, a 0-to-1 change between consecutive cycles sets that pin's state bit. A 1-to-0 change does not set it.
- R4: With the falling enable (address 1) set for a pin, a 1-to-0 change sets that pin's state bit. A 0-to-1 change does not set it.
- R5: With the high-level enable (address 2) or the low-level enable (address 3) set, the state bit is set again on every cycle the level holds. A clear therefore has no lasting effect until the level goes away.
- R6: When several trigger enables are set for one pin, that pin's event is the OR of all its enabled conditions.
- R7: Writing the state vector (address 5) clears each bit written as 1 and leaves each bit written as 0 unchanged. State bits change only through events, test writes and clears.
- R8: Writing the test register (address 6) sets each state bit written as 1. The test register always reads as zero.
- R9: State bits latch whatever the interrupt enable (address 4) holds. `irq_o` is the OR of state ANDed with enable, registered one cycle after the state and enable values it reflects.
- R10: When a hardware event and a clear hit the same state bit in the same cycle, the bit ends up set.
- R11: Every read request gets `rsp_valid` exactly one cycle later, and writes get no response. Trigger and interrupt enable registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Synchronized pin values |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | NUM_PINS | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | NUM_PINS | Read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default of 32 pins. This puts the top bit positions within reach, so the test and clear writes on bit 31 and bit 30 exercise the full width of the state, enable and mask path, not only the low pins. The bench drives each trigger type alone, then in combination. It collides a rising edge with a clear of the same bit, and holds a level across a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 3;

  // Word addresses of the register map.
  localparam logic [REG_AW-1:0] ADDR_RISE  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_FALL  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_HIGH  = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_LOW   = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_IEN   = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_STATE = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_TEST  = 3'd6;
  localparam logic [REG_AW-1:0] ADDR_PINS  = 3'd7;

  // Number of plain read/write configuration registers (addresses 0..4).
  localparam int NUM_CFG = 5;
endpackage

// File: rtl/pin_trigger_eval.sv
module pin_trigger_eval #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] high_en_i,
  input  logic [NUM_PINS-1:0] low_en_i,
  output logic [NUM_PINS-1:0] event_o
);
  // One pin: OR of every enabled condition.
  function automatic logic trig_hit(input logic rise_en, input logic fall_en,
                                    input logic high_en, input logic low_en,
                                    input logic prev, input logic cur);
    logic up, down;
    up   = cur & ~prev;
    down = prev & ~cur;
    return (rise_en & up) | (fall_en & down) | (high_en & cur) | (low_en & ~cur);
  endfunction

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign event_o[p] = trig_hit(rise_en_i[p], fall_en_i[p], high_en_i[p],
                                 low_en_i[p], prev_i[p], cur_i[p]);
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [REG_AW-1:0]               wr_addr_i,
  input  logic [NUM_PINS-1:0]             wr_data_i,
  output logic [NUM_CFG-1:0][NUM_PINS-1:0] cfg_o,
  output logic [NUM_PINS-1:0]             clr_vec_o,
  output logic [NUM_PINS-1:0]             set_vec_o
);
  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[r] <= '0;
      end else if (wr_en_i && (wr_addr_i == MY_ADDR)) begin
        cfg_o[r] <= wr_data_i;
      end
    end
  end

  // Single-cycle strobes for the write-one-to-clear and write-one-to-set ports.
  assign clr_vec_o = (wr_en_i && (wr_addr_i == ADDR_STATE)) ? wr_data_i : '0;
  assign set_vec_o = (wr_en_i && (wr_addr_i == ADDR_TEST))  ? wr_data_i : '0;
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] ien_i,
  output logic [NUM_PINS-1:0] state_o,
  output logic                irq_o
);
  // Clear first, then set: any set source overrides a clear of the same bit.
  function automatic logic [NUM_PINS-1:0] next_state(
      input logic [NUM_PINS-1:0] cur, input logic [NUM_PINS-1:0] ev,
      input logic [NUM_PINS-1:0] sw_set, input logic [NUM_PINS-1:0] sw_clr);
    return (cur & ~sw_clr) | ev | sw_set;
  endfunction

  logic [NUM_PINS-1:0] state_q;
  logic                irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= next_state(state_q, event_i, set_i, clr_i);
      irq_q   <= |(state_q & ien_i);
    end
  end

  assign state_o = state_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [REG_AW-1:0]   req_addr,
  input  logic [NUM_PINS-1:0] req_wdata,
  output logic                rsp_valid,
  output logic [NUM_PINS-1:0] rsp_rdata,
  output logic                irq_o
);
  logic [NUM_CFG-1:0][NUM_PINS-1:0] cfg;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] test_vec;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] ev_any;
  logic [NUM_PINS-1:0] state_q;
  logic [NUM_PINS-1:0] rd_mux;
  logic                wr_en;
  logic                rd_en;

  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  irq_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (req_addr),
    .wr_data_i (req_wdata),
    .cfg_o     (cfg),
    .clr_vec_o (clr_vec),
    .set_vec_o (test_vec)
  );

  // Previous-cycle copy of the pins for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins_i;
  end

  pin_trigger_eval #(.NUM_PINS(NUM_PINS)) u_eval (
    .cur_i     (pins_i),
    .prev_i    (prev_q),
    .rise_en_i (cfg[ADDR_RISE]),
    .fall_en_i (cfg[ADDR_FALL]),
    .high_en_i (cfg[ADDR_HIGH]),
    .low_en_i  (cfg[ADDR_LOW]),
    .event_o   (ev_any)
  );

  irq_state_bank #(.NUM_PINS(NUM_PINS)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (ev_any),
    .set_i   (test_vec),
    .clr_i   (clr_vec),
    .ien_i   (cfg[ADDR_IEN]),
    .state_o (state_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (req_addr)
      ADDR_RISE:  rd_mux = cfg[ADDR_RISE];
      ADDR_FALL:  rd_mux = cfg[ADDR_FALL];
      ADDR_HIGH:  rd_mux = cfg[ADDR_HIGH];
      ADDR_LOW:   rd_mux = cfg[ADDR_LOW];
      ADDR_IEN:   rd_mux = cfg[ADDR_IEN];
      ADDR_STATE: rd_mux = state_q;
      ADDR_PINS:  rd_mux = pins_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_irq_detect_checker.sv
module gpio_irq_detect_checker #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic                rsp_valid,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] state_q,
  input logic [NUM_PINS-1:0] ev_any,
  input logic [NUM_PINS-1:0] test_vec,
  input logic [NUM_PINS-1:0] clr_vec
);
  assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_any != '0) |=> ((state_q & $past(ev_any)) == $past(ev_any)));

  assert_test_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_vec != '0) |=> ((state_q & $past(test_vec)) == $past(test_vec)));

  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~ev_any) != '0) |=> ((state_q & $past(clr_vec & ~ev_any)) == '0));

  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state_q & ~$past(state_q) & ~$past(ev_any | test_vec)) == '0));

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(state_q) != '0));

  assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_write_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind gpio_irq_detect gpio_irq_detect_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .irq_o     (irq_o),
  .state_q   (state_q),
  .ev_any    (ev_any),
  .test_vec  (test_vec),
  .clr_vec   (clr_vec)
);

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
  localparam int N = 32;
  localparam logic [2:0] A_RISE = 3'd0, A_FALL = 3'd1, A_HIGH = 3'd2, A_LOW = 3'd3,
                         A_IEN = 3'd4, A_STATE = 3'd5, A_TEST = 3'd6, A_PINS = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins_i = '0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [2:0]   req_addr = '0;
  logic [N-1:0] req_wdata = '0;
  logic         rsp_valid;
  logic [N-1:0] rsp_rdata;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic [N-1:0] pv = '0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s: read actual=%h expected=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    pv = v;
    pins_i = v;
    @(negedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: missing responses actual=0 expected=%0d", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1: reset values
    chk_bit(irq_o, 1'b0, "R1 irq");
    for (int a = 0; a < 7; a++) rd(3'(a), '0, "R1");

    // R3: rising edge on pin 0
    wr(A_RISE, 32'h1);
    set_pins(32'h1);
    rd(A_STATE, 32'h1, "R3 rise");
    set_pins(32'h0);
    wr(A_STATE, 32'h1);
    rd(A_STATE, 32'h0, "R3 no fall event");

    // R4: falling edge on pin 1
    wr(A_FALL, 32'h2);
    set_pins(32'h2);
    rd(A_STATE, 32'h0, "R4 no rise event");
    set_pins(32'h0);
    rd(A_STATE, 32'h2, "R4 fall");
    wr(A_STATE, 32'h2);
    rd(A_STATE, 32'h0, "R4 cleared");

    // R5: high level on pin 2 survives a clear while held
    wr(A_HIGH, 32'h4);
    set_pins(32'h4);
    rd(A_STATE, 32'h4, "R5 high");
    wr(A_STATE, 32'h4);
    rd(A_STATE, 32'h4, "R5 held level resets");
    set_pins(32'h0);
    wr(A_STATE, 32'h4);
    rd(A_STATE, 32'h0, "R5 cleared after release");
    wr(A_HIGH, 32'h0);

    // R5: low level on pin 3 (pin already low)
    wr(A_LOW, 32'h8);
    tick();
    rd(A_STATE, 32'h8, "R5 low");
    set_pins(32'h8);
    wr(A_STATE, 32'h8);
    rd(A_STATE, 32'h0, "R5 low cleared");
    wr(A_LOW, 32'h0);

    // R6: rising plus falling on pin 4
    wr(A_RISE, 32'h11);
    wr(A_FALL, 32'h12);
    set_pins(pv | 32'h10);
    rd(A_STATE, 32'h10, "R6 rise part");
    wr(A_STATE, 32'h10);
    set_pins(pv & ~32'h10);
    rd(A_STATE, 32'h10, "R6 fall part");
    wr(A_STATE, 32'h10);
    rd(A_STATE, 32'h0, "R6 cleared");

    // R8 / R7 / R9: test set on bit 31, masked interrupt
    wr(A_TEST, 32'h8000_0000);
    rd(A_STATE, 32'h8000_0000, "R8 test sets");
    rd(A_TEST, 32'h0, "R8 reads zero");
    wr(A_STATE, 32'h0000_0001);
    rd(A_STATE, 32'h8000_0000, "R7 zero bits kept");
    tick();
    chk_bit(irq_o, 1'b0, "R9 latched but disabled");
    wr(A_IEN, 32'h8000_0000);
    chk_bit(irq_o, 1'b0, "R9 one cycle delay");
    tick();
    chk_bit(irq_o, 1'b1, "R9 irq asserted");
    wr(A_STATE, 32'h8000_0000);
    tick();
    chk_bit(irq_o, 1'b0, "R9 irq drops after clear");
    wr(A_TEST, 32'h4000_0000);
    tick();
    tick();
    chk_bit(irq_o, 1'b0, "R9 bit 30 masked");
    rd(A_STATE, 32'h4000_0000, "R9 state latched");
    wr(A_STATE, 32'h4000_0000);

    // R10: rising edge and clear of the same bit in one cycle
    wr(A_TEST, 32'h1);
    pv = pv | 32'h1;
    pins_i = pv;
    wr(A_STATE, 32'h1);
    rd(A_STATE, 32'h1, "R10 set wins");
    set_pins(pv & ~32'h1);
    wr(A_STATE, 32'h1);
    rd(A_STATE, 32'h0, "R10 cleared later");

    // R2: pin data readback
    set_pins(32'hC3A5_0F08);
    rd(A_PINS, 32'hC3A5_0F08, "R2 pins a");
    set_pins(32'h5A5A_F00F);
    rd(A_PINS, 32'h5A5A_F00F, "R2 pins b");

    // R11: configuration readback and no response to writes
    rd(A_RISE, 32'h11, "R11 rise readback");
    rd(A_IEN, 32'h8000_0000, "R11 ien readback");
    wr(A_HIGH, 32'h0);
    chk_bit(rsp_valid, 1'b0, "R11 write no response");

    tick();
    finish_run();
  end
endmodule